// File: doc/BRIEF.md
# Two-Wire Slave Front End for a Digital Potentiometer

This block is the serial bus front end of a digitally controlled potentiometer. It watches the clock and data lines of a two-wire bus. Both lines are sampled on a faster system clock. The block finds START and STOP conditions and accepts an address byte made of a fixed device-type code and two strap bits. It acknowledges the bytes it accepts. Received bytes go to a command executor as strobed parallel data. In a read, the block shifts out bytes that the executor supplies. The executor also reports when a slow internal store is running. During that time the slave refuses its own address, so a host can poll for the end of the store by sending the address until the slave acknowledges it.

The data line is driven through an active-high pull-down enable. The slave never stretches the clock. Command meaning, register storage and analog behaviour belong to the executor and are not part of this block.

Top module: `dpot_twowire_slave`

## Requirements
- R1: After reset the pull-down enable is off and none of the strobes (byte received, read byte taken, transaction end) is active.
- R2: A START is the data line falling while the clock line is high, and a STOP is the data line rising while the clock line is high. Until the first START, clocked bits are ignored: no acknowledge and no strobe.
- R3: The first byte after START is received MSB first and is 0101, then 0, then the two strap bits (strap bit 1 before strap bit 0), then the direction bit (1 = read). On a full match the slave pulls the data line low for the ninth clock. On any mismatch it does not acknowledge, and it ignores the bus until the next START.
- R4: While the store-busy input is high at the moment the eighth address bit is evaluated, the address is not acknowledged. Once the input is low, the same address is acknowledged.
- R5: In a write, each further byte is presented on the received-data output with a one-cycle strobe. The slave acknowledges it on the ninth clock.
- R6: In a read, after the address acknowledge, the slave takes a byte from the read-data input, pulses the read-taken strobe, and drives the byte MSB first. Each bit changes only after a clock fall. The line is released for the ninth clock.
- R7: A master acknowledge (data line low on the ninth clock) makes the slave take and send the next byte. A master non-acknowledge stops all driving until the next STOP or START.
- R8: A STOP while the slave is addressed pulses the transaction-end strobe for exactly one cycle and returns it to idle, even in the middle of a byte. A STOP while idle gives no strobe.
- R9: A repeated START at any point restarts the address phase without a transaction-end strobe.
- R10: The read-mode output holds the direction bit of the accepted address for the rest of the transaction.
- R11: The pull-down enable only turns on while the synchronized clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| dev_addr_i | input | 2 | Strap bits that the address byte must match |
| nv_busy_i | input | 1 | High while the internal nonvolatile store runs |
| rd_data_i | input | 8 | Next byte to send in a read |
| sda_oe_o | output | 1 | Pull the data line low when high |
| rx_valid_o | output | 1 | One-cycle strobe: rx_data_o holds a received byte |
| rx_data_o | output | 8 | Received data byte |
| rd_req_o | output | 1 | One-cycle strobe: rd_data_i was taken |
| rd_mode_o | output | 1 | Direction of the current transaction (1 = read) |
| txn_end_o | output | 1 | One-cycle strobe on STOP while addressed |

## Verification
The busy flag and the address evaluation can change in the same cycle. The busy input may toggle on the very system clock where the eighth address bit's clock edge arrives. The bench provokes this by raising or dropping busy on the same clock as that rising edge. The busy value that holds when the synchronized edge reaches the controller must decide the answer. So a release must give an acknowledge, and a late assertion must give a refusal. Each case is judged from the level on the wire during the ninth clock.

// File: rtl/dpot_tw_pkg.sv
package dpot_tw_pkg;
    localparam int          BYTE_W    = 8;
    localparam int          CNT_W     = $clog2(BYTE_W);
    localparam int          STRAP_W   = 2;
    localparam int          SYNC_LEN  = 2;
    localparam logic [3:0]  TYPE_CODE = 4'b0101;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_WAIT,
        ST_ACK,
        ST_WR,
        ST_RD,
        ST_MACK,
        ST_RD_NEXT,
        ST_HOLD
    } tw_state_e;

    typedef struct packed {
        tw_state_e          st;
        logic [CNT_W-1:0]   cnt;
        logic [BYTE_W-1:0]  sh;
        logic               oe;
        logic               rw;
        logic               rxv;
        logic               rdr;
        logic               endp;
    } tw_regs_t;
endpackage

// File: rtl/dpot_tw_lines.sv
module dpot_tw_lines #(
    parameter int STAGES = 2,
    parameter int N      = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] cur_o,
    output logic [N-1:0] prev_o
);
    for (genvar g = 0; g < N; g++) begin : g_line
        logic [STAGES:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-1:0], raw_i[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= chain_d;
        end

        assign cur_o[g]  = chain_q[STAGES-1];
        assign prev_o[g] = chain_q[STAGES];
    end
endmodule

// File: rtl/dpot_tw_cond.sv
module dpot_tw_cond (
    input  logic scl_cur,
    input  logic scl_prev,
    input  logic sda_cur,
    input  logic sda_prev,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_c,
    output logic stop_c
);
    always_comb begin
        scl_rise = scl_cur & ~scl_prev;
        scl_fall = ~scl_cur & scl_prev;
        start_c  = scl_cur & scl_prev & sda_prev & ~sda_cur;
        stop_c   = scl_cur & scl_prev & ~sda_prev & sda_cur;
    end
endmodule

// File: rtl/dpot_tw_ctrl.sv
module dpot_tw_ctrl
    import dpot_tw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               start_c,
    input  logic               stop_c,
    input  logic               sda_s,
    input  logic [STRAP_W-1:0] dev_addr_i,
    input  logic               nv_busy_i,
    input  logic [BYTE_W-1:0]  rd_data_i,
    output logic               sda_oe_o,
    output logic               rx_valid_o,
    output logic [BYTE_W-1:0]  rx_data_o,
    output logic               rd_req_o,
    output logic               rd_mode_o,
    output logic               txn_end_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    tw_regs_t q, d;
    logic [BYTE_W-1:0] shin;
    logic              addr_hit;

    always_comb begin
        shin     = {q.sh[BYTE_W-2:0], sda_s};
        addr_hit = (shin[7:4] == TYPE_CODE) && !shin[3] &&
                   (shin[2:1] == dev_addr_i) && !nv_busy_i;

        d      = q;
        d.rxv  = 1'b0;
        d.rdr  = 1'b0;
        d.endp = 1'b0;

        if (start_c) begin
            d.st  = ST_ADDR;
            d.cnt = '0;
            d.oe  = 1'b0;
            d.rw  = 1'b0;
        end else if (stop_c) begin
            d.endp = (q.st != ST_IDLE);
            d.st   = ST_IDLE;
            d.oe   = 1'b0;
        end else begin
            unique case (q.st)
                ST_ADDR: if (scl_rise) begin
                    d.sh = shin;
                    if (q.cnt == LAST) begin
                        d.cnt = '0;
                        if (addr_hit) begin
                            d.rw = shin[0];
                            d.st = ST_ACK_WAIT;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_ACK_WAIT: if (scl_fall) begin
                    d.oe = 1'b1;
                    d.st = ST_ACK;
                end
                ST_ACK, ST_RD_NEXT: if (scl_fall) begin
                    d.cnt = '0;
                    if (q.rw) begin
                        d.sh  = rd_data_i;
                        d.oe  = ~rd_data_i[BYTE_W-1];
                        d.rdr = 1'b1;
                        d.st  = ST_RD;
                    end else begin
                        d.oe = 1'b0;
                        d.st = ST_WR;
                    end
                end
                ST_WR: if (scl_rise) begin
                    d.sh = shin;
                    if (q.cnt == LAST) begin
                        d.cnt = '0;
                        d.rxv = 1'b1;
                        d.st  = ST_ACK_WAIT;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_RD: if (scl_fall) begin
                    if (q.cnt == LAST) begin
                        d.oe = 1'b0;
                        d.st = ST_MACK;
                    end else begin
                        d.sh  = {q.sh[BYTE_W-2:0], 1'b0};
                        d.oe  = ~q.sh[BYTE_W-2];
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_MACK: if (scl_rise) begin
                    d.st = sda_s ? ST_HOLD : ST_RD_NEXT;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o   = q.oe;
    assign rx_valid_o = q.rxv;
    assign rx_data_o  = q.sh;
    assign rd_req_o   = q.rdr;
    assign rd_mode_o  = q.rw;
    assign txn_end_o  = q.endp;
endmodule

// File: rtl/dpot_twowire_slave.sv
module dpot_twowire_slave
    import dpot_tw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] dev_addr_i,
    input  logic               nv_busy_i,
    input  logic [BYTE_W-1:0]  rd_data_i,
    output logic               sda_oe_o,
    output logic               rx_valid_o,
    output logic [BYTE_W-1:0]  rx_data_o,
    output logic               rd_req_o,
    output logic               rd_mode_o,
    output logic               txn_end_o
);
    logic [1:0] line_cur, line_prev;
    logic       scl_s, scl_rise, scl_fall, start_c, stop_c;

    dpot_tw_lines #(.STAGES(SYNC_LEN), .N(2)) u_lines (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({scl_i, sda_i}),
        .cur_o  (line_cur),
        .prev_o (line_prev)
    );

    assign scl_s = line_cur[1];

    dpot_tw_cond u_cond (
        .scl_cur  (line_cur[1]),
        .scl_prev (line_prev[1]),
        .sda_cur  (line_cur[0]),
        .sda_prev (line_prev[0]),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_c  (start_c),
        .stop_c   (stop_c)
    );

    dpot_tw_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_c    (start_c),
        .stop_c     (stop_c),
        .sda_s      (line_cur[0]),
        .dev_addr_i (dev_addr_i),
        .nv_busy_i  (nv_busy_i),
        .rd_data_i  (rd_data_i),
        .sda_oe_o   (sda_oe_o),
        .rx_valid_o (rx_valid_o),
        .rx_data_o  (rx_data_o),
        .rd_req_o   (rd_req_o),
        .rd_mode_o  (rd_mode_o),
        .txn_end_o  (txn_end_o)
    );
endmodule

// File: rtl/dpot_tw_chk.sv
module dpot_tw_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic start_c,
    input logic sda_oe_o,
    input logic rx_valid_o,
    input logic rd_req_o,
    input logic rd_mode_o,
    input logic txn_end_o
);
    AST_OE_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_s); // R11
    AST_RX_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> !rd_mode_o); // R5
    AST_RDREQ_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> rd_mode_o); // R6
    AST_END_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        txn_end_o |=> !txn_end_o); // R8
    AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        start_c |=> !sda_oe_o); // R9
    AST_RX_NOT_END: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> !txn_end_o); // R8
endmodule

bind dpot_twowire_slave dpot_tw_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (scl_s),
    .start_c    (start_c),
    .sda_oe_o   (sda_oe_o),
    .rx_valid_o (rx_valid_o),
    .rd_req_o   (rd_req_o),
    .rd_mode_o  (rd_mode_o),
    .txn_end_o  (txn_end_o)
);

// File: tb/dpot_twowire_slave_tb_top.sv
`timescale 1ns/1ps
module dpot_twowire_slave_tb_top;
    localparam int Q = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic [1:0] dev_addr = 2'b10;
    logic       nv_busy = 1'b0;
    logic [7:0] rd_data = 8'hA5;
    logic       sda_oe, rx_valid, rd_req, rd_mode, txn_end;
    logic [7:0] rx_data;
    wire        sda_line = sda_m & ~sda_oe;

    int n_chk = 0, n_err = 0, end_cnt = 0, req_cnt = 0;
    logic care = 1'b0, exp_oe = 1'b0, done = 1'b0;
    logic [7:0] rxq[$];

    always #2 clk = ~clk;

    dpot_twowire_slave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .dev_addr_i(dev_addr), .nv_busy_i(nv_busy), .rd_data_i(rd_data),
        .sda_oe_o(sda_oe), .rx_valid_o(rx_valid), .rx_data_o(rx_data),
        .rd_req_o(rd_req), .rd_mode_o(rd_mode), .txn_end_o(txn_end)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // per-clock reference comparison
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (care) chk(sda_oe === exp_oe, "R3/R6/R7 pull-down level", sda_oe, exp_oe);
            if (rx_valid) begin
                if (rxq.size() == 0) chk(1'b0, "R5 unexpected byte strobe", rx_data, 0);
                else begin
                    logic [7:0] e;
                    e = rxq.pop_front();
                    chk(rx_data === e, "R5 received byte", rx_data, e);
                end
            end
            if (txn_end) end_cnt++;
            if (rd_req) begin
                req_cnt++;
                rd_data = rd_data + 8'h11;
            end
        end
    end

    task automatic clk_bit(input logic drv, input logic exp_low, input int busy_set, output logic seen);
        sda_m = drv;
        repeat (Q) @(negedge clk);
        scl_m = 1'b1;
        if (busy_set >= 0) nv_busy = busy_set[0];
        exp_oe = exp_low;
        care = 1'b1;
        repeat (Q) @(negedge clk);
        seen = sda_line;
        repeat (Q) @(negedge clk);
        care = 1'b0;
        scl_m = 1'b0;
        repeat (Q) @(negedge clk);
    endtask

    task automatic start_c();
        sda_m = 1'b1; repeat (Q) @(negedge clk);
        scl_m = 1'b1; repeat (Q) @(negedge clk);
        sda_m = 1'b0; repeat (Q) @(negedge clk);
        scl_m = 1'b0; repeat (Q) @(negedge clk);
    endtask

    task automatic stop_c();
        sda_m = 1'b0; repeat (Q) @(negedge clk);
        scl_m = 1'b1; repeat (Q) @(negedge clk);
        sda_m = 1'b1; repeat (2*Q) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req, input int busy_last = -1);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], 1'b0, (i == 0) ? busy_last : -1, s);
        clk_bit(1'b1, exp_ack, -1, s);
        chk(~s == exp_ack, req, ~s, exp_ack);
    endtask

    task automatic recv_byte(input logic [7:0] e, input logic mack, input string req);
        logic s;
        logic [7:0] got;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, ~e[i], -1, s);
            got[i] = s;
        end
        clk_bit(~mack, 1'b0, -1, s);
        chk(got === e, req, got, e);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int e0;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk({sda_oe, rx_valid, rd_req, txn_end} === 4'b0, "R1 reset outputs", {sda_oe, rx_valid, rd_req, txn_end}, 0);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        chk({sda_oe, rx_valid, rd_req, txn_end} === 4'b0, "R1 idle after reset", {sda_oe, rx_valid, rd_req, txn_end}, 0);

        // R2 matching byte without START is ignored
        scl_m = 1'b0; repeat (Q) @(negedge clk);
        send_byte(8'h54, 1'b0, "R2 no ack before START");
        send_byte(8'h3C, 1'b0, "R2 no ack on data before START");
        stop_c();
        chk(end_cnt == 0, "R2 no end strobe", end_cnt, 0);

        // R5 R10 write transaction
        start_c();
        send_byte(8'h54, 1'b1, "R3 address ack write");
        chk(rd_mode == 1'b0, "R10 write mode", rd_mode, 0);
        rxq.push_back(8'h3C);
        send_byte(8'h3C, 1'b1, "R5 first byte ack");
        rxq.push_back(8'hC3);
        send_byte(8'hC3, 1'b1, "R5 second byte ack");
        stop_c();
        chk(end_cnt == 1, "R8 end strobe after write", end_cnt, 1);
        chk(rxq.size() == 0, "R5 all bytes delivered", rxq.size(), 0);

        // R3 mismatches: strap, type code, zero bit
        start_c();
        send_byte(8'h52, 1'b0, "R3 strap mismatch nack");
        send_byte(8'h11, 1'b0, "R3 ignored after mismatch");
        stop_c();
        start_c();
        send_byte(8'h74, 1'b0, "R3 type code mismatch nack");
        stop_c();
        start_c();
        send_byte(8'h5C, 1'b0, "R3 zero bit violation nack");
        stop_c();
        chk(end_cnt == 1, "R8 no end strobe while idle", end_cnt, 1);

        // R4 busy polling
        nv_busy = 1'b1;
        start_c();
        send_byte(8'h54, 1'b0, "R4 busy nack");
        stop_c();
        nv_busy = 1'b0;
        start_c();
        send_byte(8'h54, 1'b1, "R4 ack after busy");
        stop_c();
        chk(end_cnt == 2, "R8 end after poll", end_cnt, 2);

        // R4 busy changes on the last address clock edge
        nv_busy = 1'b1;
        start_c();
        send_byte(8'h54, 1'b1, "R4 release at last bit acks", 0);
        stop_c();
        start_c();
        send_byte(8'h54, 1'b0, "R4 busy at last bit nacks", 1);
        stop_c();
        nv_busy = 1'b0;

        // R6 R7 R10 read transaction
        rd_data = 8'hA5;
        e0 = req_cnt;
        start_c();
        send_byte(8'h55, 1'b1, "R3 address ack read");
        chk(rd_mode == 1'b1, "R10 read mode", rd_mode, 1);
        recv_byte(8'hA5, 1'b1, "R6 first read byte");
        recv_byte(8'hB6, 1'b0, "R7 next byte after master ack");
        recv_byte(8'hFF, 1'b0, "R7 released after master nack");
        stop_c();
        chk(req_cnt - e0 == 2, "R6 read-taken strobes", req_cnt - e0, 2);
        chk(end_cnt == 4, "R8 end after read", end_cnt, 4);

        // R9 repeated start
        start_c();
        send_byte(8'h54, 1'b1, "R9 write address");
        rxq.push_back(8'h11);
        send_byte(8'h11, 1'b1, "R9 byte before restart");
        start_c();
        chk(end_cnt == 4, "R9 no end on restart", end_cnt, 4);
        rd_data = 8'h5A;
        send_byte(8'h55, 1'b1, "R9 read address after restart");
        recv_byte(8'h5A, 1'b0, "R9 read after restart");
        stop_c();
        chk(end_cnt == 5, "R9 single end strobe", end_cnt, 5);

        // R8 stop in the middle of a byte
        start_c();
        send_byte(8'h54, 1'b1, "R8 address");
        begin
            logic s;
            for (int i = 0; i < 4; i++) clk_bit(1'b1, 1'b0, -1, s);
        end
        stop_c();
        chk(end_cnt == 6, "R8 end on mid-byte stop", end_cnt, 6);
        chk(rxq.size() == 0, "R8 no partial byte", rxq.size(), 0);
        start_c();
        send_byte(8'h54, 1'b1, "R8 usable after abort");
        stop_c();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule